// File: doc/BRIEF.md
# MSI Vector Dispatcher with Pending Replay

This block turns per-vector interrupt requests from a device function into message-signalled interrupt memory writes. A requester presents a vector number with a valid/ready handshake. The block reads the capability register values (enable, the log2 of the enabled vector count, the message address words, the message data word, the per-vector mask and the per-vector pending bits) and takes one of three actions. It builds a dword write message, or it flags the request as illegal, or, when the vector is masked, it asks the register file to set that vector's pending bit.

The pending bits live outside the block. The block reports changes to them through one-cycle set and clear vectors, which the register file applies at the next clock edge. After every configuration write made while MSI is enabled, the block runs a replay scan. The scan first clears the pending bits at or above the enabled vector count. It then walks the vectors from 0 upward and, for each vector that is pending and unmasked, clears its pending bit and delivers its message. Only one message is outstanding at any time.

Parameters select the largest vector count and whether the function has a 64-bit address and per-vector masking.

Top module: `msi_vector_dispatch`

## Requirements
- R1: With MSI enabled, an accepted request whose vector is greater than or equal to the enabled count N raises `req_err` for that acceptance cycle only. It produces no message and leaves `pend_set` at zero.
- R2: With the 64-bit option, `msg_addr` is {`cfg_addr_hi`, `cfg_addr_lo`[31:2], 2'b00}. Without it, `msg_addr` is {32'h0, `cfg_addr_lo`[31:2], 2'b00}.
- R3: `msg_data`[31:16] is zero. When N > 1, bits [log2(N)-1:0] of `msg_data` carry the vector number and the remaining low bits come from `cfg_data`. When N = 1, the low 16 bits equal `cfg_data`.
- R4: With masking supported and MSI enabled, an accepted legal request whose `cfg_mask` bit is 1 drives `pend_set` one-hot at that vector in the acceptance cycle and sends no message.
- R5: Without masking support, the mask and pending inputs have no effect: a masked vector is still delivered, and `pend_set` and `pend_clr` stay zero.
- R6: A `cfg_wr` pulse while enabled starts a replay scan once the block is idle. The scan visits vectors in ascending order. For each vector that is pending and unmasked, `pend_clr` is one-hot at that vector in the same cycle the message is loaded, and `msg_valid` rises in the next cycle.
- R7: In the first cycle of a replay scan, `pend_clr` clears every pending bit at or above N.
- R8: At most one message is outstanding. While `msg_valid` is high, or while a scan is requested or running, `req_ready` is low. `msg_addr` and `msg_data` hold steady until `msg_ready` is seen.
- R9: While `cfg_enable` is 0, accepted requests produce no message, no `req_err` and no `pend_set`, and `cfg_wr` starts no scan.
- R10: Every message is a full dword write: `msg_be` is 4'hF, and byte k of the dword is `msg_data`[8k+7:8k].
- R11: N is 2 to the power of `cfg_log_vecs`. Any value of `cfg_log_vecs` above log2(`NUM_VEC_MAX`) counts as log2(`NUM_VEC_MAX`).
- R12: After reset, `msg_valid` is 0, `req_ready` is 1 and no scan is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | MSI enable from the capability control word |
| cfg_log_vecs | input | 3 | log2 of the enabled vector count |
| cfg_addr_lo | input | 32 | Lower message address word |
| cfg_addr_hi | input | 32 | Upper message address word (used only with the 64-bit option) |
| cfg_data | input | 16 | Base message data |
| cfg_mask | input | NUM_VEC_MAX | Per-vector mask bits |
| cfg_pending | input | NUM_VEC_MAX | Per-vector pending bits held by the register file |
| cfg_wr | input | 1 | One-cycle pulse for any write to the capability |
| req_valid | input | 1 | Interrupt request valid |
| req_vec | input | log2(NUM_VEC_MAX) | Requested vector |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_err | output | 1 | Illegal vector flagged in the acceptance cycle |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address, dword aligned |
| msg_data | output | 32 | Message data |
| msg_be | output | 4 | Byte enables |
| pend_set | output | NUM_VEC_MAX | Pending bits to set at the next edge |
| pend_clr | output | NUM_VEC_MAX | Pending bits to clear at the next edge |

## Verification
The hardest state to reach from the ports is a replay scan that finds several pending vectors interleaved with masked ones, while the message sink stalls at random in the middle of the walk. The scan must then resume at the correct vector after each handshake. To get there, the bench masks a set of vectors, requests them out of order so that they pile up as pending, and then issues a configuration write that unmasks some or all of them with `msg_ready` toggling pseudo-randomly. A second case shrinks the vector count below an existing pending bit before the write, which exercises the out-of-range discard.

// File: rtl/msi_disp_pkg.sv
package msi_disp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_SCAN = 2'd2
   } disp_state_e;

   localparam int LOG_FIELD_W = 3;
   localparam int MSG_ADDR_W  = 64;
   localparam int MSG_DATA_W  = 32;
   localparam int BASE_DATA_W = 16;
   localparam int MSG_BE_W    = MSG_DATA_W / 8;
endpackage

// File: rtl/msi_vec_window.sv
module msi_vec_window
   import msi_disp_pkg::*;
#(
   parameter int NUM_VEC_MAX = 32,
   localparam int VEC_W = $clog2(NUM_VEC_MAX)
) (
   input  logic [LOG_FIELD_W-1:0] log_req,
   input  logic [VEC_W-1:0]       vec,
   output logic [NUM_VEC_MAX-1:0] in_range,
   output logic [VEC_W-1:0]       low_sel,
   output logic                   vec_ok,
   output logic                   vec_last
);
   localparam logic [LOG_FIELD_W-1:0] LOG_MAX = LOG_FIELD_W'(VEC_W);

   logic [LOG_FIELD_W-1:0] lg_eff;

   assign lg_eff = (log_req > LOG_MAX) ? LOG_MAX : log_req;

   for (genvar i = 0; i < NUM_VEC_MAX; i++) begin : g_range
      assign in_range[i] = ((32'(i) >> lg_eff) == 32'd0);
   end

   for (genvar b = 0; b < VEC_W; b++) begin : g_sel
      assign low_sel[b] = (LOG_FIELD_W'(b) < lg_eff);
   end

   assign vec_ok   = in_range[vec];
   assign vec_last = (vec == low_sel);
endmodule

// File: rtl/msi_msg_former.sv
module msi_msg_former
   import msi_disp_pkg::*;
#(
   parameter int  VEC_W      = 5,
   parameter bit  HAS_ADDR64 = 1'b1
) (
   input  logic [31:0]             addr_lo,
   input  logic [31:0]             addr_hi,
   input  logic [BASE_DATA_W-1:0]  base_data,
   input  logic [VEC_W-1:0]        low_sel,
   input  logic [VEC_W-1:0]        vec,
   output logic [MSG_ADDR_W-1:0]   addr,
   output logic [MSG_DATA_W-1:0]   data
);
   logic [BASE_DATA_W-1:0] low_word;
   logic                   unused_lo_bits;

   assign unused_lo_bits = ^addr_lo[1:0];

   if (HAS_ADDR64) begin : g_addr64
      assign addr = {addr_hi, addr_lo[31:2], 2'b00};
   end else begin : g_addr32
      logic unused_hi_word;
      assign unused_hi_word = ^addr_hi;
      assign addr = {32'h0, addr_lo[31:2], 2'b00};
   end

   for (genvar b = 0; b < BASE_DATA_W; b++) begin : g_data
      if (b < VEC_W) begin : g_sub
         assign low_word[b] = low_sel[b] ? vec[b] : base_data[b];
      end else begin : g_keep
         assign low_word[b] = base_data[b];
      end
   end

   assign data = {{(MSG_DATA_W-BASE_DATA_W){1'b0}}, low_word};
endmodule

// File: rtl/msi_mask_gate.sv
module msi_mask_gate #(
   parameter int NUM_VEC_MAX = 32,
   parameter bit HAS_MASK    = 1'b1
) (
   input  logic [NUM_VEC_MAX-1:0] mask_in,
   input  logic [NUM_VEC_MAX-1:0] pend_in,
   output logic [NUM_VEC_MAX-1:0] mask_eff,
   output logic [NUM_VEC_MAX-1:0] pend_eff,
   output logic                   scan_ok
);
   if (HAS_MASK) begin : g_masked
      assign mask_eff = mask_in;
      assign pend_eff = pend_in;
      assign scan_ok  = 1'b1;
   end else begin : g_unmasked
      logic unused_mask_bits;
      assign unused_mask_bits = ^{mask_in, pend_in};
      assign mask_eff = '0;
      assign pend_eff = '0;
      assign scan_ok  = 1'b0;
   end
endmodule

// File: rtl/msi_vector_dispatch.sv
module msi_vector_dispatch
   import msi_disp_pkg::*;
#(
   parameter int NUM_VEC_MAX = 32,
   parameter bit HAS_ADDR64  = 1'b1,
   parameter bit HAS_MASK    = 1'b1,
   localparam int VEC_W = $clog2(NUM_VEC_MAX)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_enable,
   input  logic [2:0]             cfg_log_vecs,
   input  logic [31:0]            cfg_addr_lo,
   input  logic [31:0]            cfg_addr_hi,
   input  logic [15:0]            cfg_data,
   input  logic [NUM_VEC_MAX-1:0] cfg_mask,
   input  logic [NUM_VEC_MAX-1:0] cfg_pending,
   input  logic                   cfg_wr,
   input  logic                   req_valid,
   input  logic [VEC_W-1:0]       req_vec,
   output logic                   req_ready,
   output logic                   req_err,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [63:0]            msg_addr,
   output logic [31:0]            msg_data,
   output logic [3:0]             msg_be,
   output logic [NUM_VEC_MAX-1:0] pend_set,
   output logic [NUM_VEC_MAX-1:0] pend_clr
);
   if (NUM_VEC_MAX < 2 || NUM_VEC_MAX > 32 || (1 << VEC_W) != NUM_VEC_MAX) begin : g_bad_count
      $error("NUM_VEC_MAX must be a power of two from 2 to 32");
   end

   localparam logic [NUM_VEC_MAX-1:0] ONE_HOT0 = {{(NUM_VEC_MAX-1){1'b0}}, 1'b1};

   disp_state_e             state_q, state_d;
   logic [VEC_W-1:0]        idx_q, idx_d;
   logic                    ret_scan_q, ret_scan_d;
   logic                    scan_req_q, scan_req_d;
   logic [MSG_ADDR_W-1:0]   addr_q, addr_nx;
   logic [MSG_DATA_W-1:0]   data_q, data_nx;
   logic                    load;

   logic [VEC_W-1:0]        sel_vec;
   logic [NUM_VEC_MAX-1:0]  in_range;
   logic [VEC_W-1:0]        low_sel;
   logic                    vec_ok;
   logic                    vec_last;
   logic [NUM_VEC_MAX-1:0]  vec_onehot;
   logic [NUM_VEC_MAX-1:0]  mask_eff;
   logic [NUM_VEC_MAX-1:0]  pend_eff;
   logic                    scan_ok;
   logic                    scan_hit;
   logic                    vec_masked;

   assign sel_vec    = (state_q == ST_SCAN) ? idx_q : req_vec;
   assign vec_onehot = ONE_HOT0 << sel_vec;
   assign scan_hit   = |(pend_eff & ~mask_eff & vec_onehot);
   assign vec_masked = |(mask_eff & vec_onehot);

   msi_vec_window #(
      .NUM_VEC_MAX (NUM_VEC_MAX)
   ) i_window (
      .log_req  (cfg_log_vecs),
      .vec      (sel_vec),
      .in_range (in_range),
      .low_sel  (low_sel),
      .vec_ok   (vec_ok),
      .vec_last (vec_last)
   );

   msi_mask_gate #(
      .NUM_VEC_MAX (NUM_VEC_MAX),
      .HAS_MASK    (HAS_MASK)
   ) i_gate (
      .mask_in  (cfg_mask),
      .pend_in  (cfg_pending),
      .mask_eff (mask_eff),
      .pend_eff (pend_eff),
      .scan_ok  (scan_ok)
   );

   msi_msg_former #(
      .VEC_W      (VEC_W),
      .HAS_ADDR64 (HAS_ADDR64)
   ) i_former (
      .addr_lo   (cfg_addr_lo),
      .addr_hi   (cfg_addr_hi),
      .base_data (cfg_data),
      .low_sel   (low_sel),
      .vec       (sel_vec),
      .addr      (addr_nx),
      .data      (data_nx)
   );

   assign req_ready = (state_q == ST_IDLE) && !scan_req_q;

   always_comb begin
      state_d    = state_q;
      idx_d      = idx_q;
      ret_scan_d = ret_scan_q;
      load       = 1'b0;
      req_err    = 1'b0;
      pend_set   = '0;
      pend_clr   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (scan_req_q) begin
               if (cfg_enable) begin
                  pend_clr = pend_eff & ~in_range;
                  state_d  = ST_SCAN;
                  idx_d    = '0;
               end
            end else if (req_valid && cfg_enable) begin
               if (!vec_ok) begin
                  req_err = 1'b1;
               end else if (vec_masked) begin
                  pend_set = vec_onehot;
               end else begin
                  load       = 1'b1;
                  state_d    = ST_SEND;
                  ret_scan_d = 1'b0;
               end
            end
         end
         ST_SEND: begin
            if (msg_ready) begin
               state_d = ret_scan_q ? ST_SCAN : ST_IDLE;
            end
         end
         ST_SCAN: begin
            if (!cfg_enable || !vec_ok) begin
               state_d = ST_IDLE;
            end else if (scan_hit) begin
               pend_clr   = vec_onehot;
               load       = 1'b1;
               state_d    = ST_SEND;
               ret_scan_d = !vec_last;
               idx_d      = idx_q + VEC_W'(1);
            end else if (vec_last) begin
               state_d = ST_IDLE;
            end else begin
               idx_d = idx_q + VEC_W'(1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign scan_req_d = (scan_req_q && (state_q != ST_IDLE)) ||
                       (cfg_wr && cfg_enable && scan_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         ret_scan_q <= 1'b0;
         scan_req_q <= 1'b0;
         addr_q     <= '0;
         data_q     <= '0;
      end else begin
         state_q    <= state_d;
         idx_q      <= idx_d;
         ret_scan_q <= ret_scan_d;
         scan_req_q <= scan_req_d;
         if (load) begin
            addr_q <= addr_nx;
            data_q <= data_nx;
         end
      end
   end

   assign msg_valid = (state_q == ST_SEND);
   assign msg_addr  = addr_q;
   assign msg_data  = data_q;
   assign msg_be    = {MSG_BE_W{1'b1}};
endmodule

// File: rtl/msi_vector_dispatch_chk.sv
module msi_vector_dispatch_chk #(
   parameter int NUM_VEC_MAX = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_enable,
   input logic                   req_ready,
   input logic                   req_err,
   input logic                   msg_valid,
   input logic                   msg_ready,
   input logic [63:0]            msg_addr,
   input logic [31:0]            msg_data,
   input logic [NUM_VEC_MAX-1:0] pend_set
);
   // R8
   held_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);

   // R4
   set_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_set));

   // R4
   masked_nomsg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set != '0) |=> !msg_valid);

   // R1
   illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> !msg_valid);

   // R3
   data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_data[31:16] == 16'h0));

   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |-> (pend_set == '0) && !req_err);
endmodule

bind msi_vector_dispatch msi_vector_dispatch_chk #(
   .NUM_VEC_MAX (NUM_VEC_MAX)
) i_dispatch_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .req_ready  (req_ready),
   .req_err    (req_err),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_addr   (msg_addr),
   .msg_data   (msg_data),
   .pend_set   (pend_set)
);

// File: tb/test_msi_vector_dispatch.sv
`timescale 1ns/1ps
module test_msi_vector_dispatch;
   localparam int NV = 32;
   localparam int VW = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          cfg_enable;
   logic [2:0]    cfg_log_vecs;
   logic [31:0]   cfg_addr_lo, cfg_addr_hi;
   logic [15:0]   cfg_data;
   logic [NV-1:0] cfg_mask;
   logic [NV-1:0] pend_reg;
   logic          cfg_wr;
   logic          req_valid, req_valid_l;
   logic [VW-1:0] req_vec;
   logic          msg_ready;
   int            rdy_mode;

   logic          req_ready, req_err, msg_valid;
   logic [63:0]   msg_addr;
   logic [31:0]   msg_data;
   logic [3:0]    msg_be;
   logic [NV-1:0] pend_set, pend_clr;

   logic          req_ready_l, req_err_l, msg_valid_l;
   logic [63:0]   msg_addr_l;
   logic [31:0]   msg_data_l;
   logic [3:0]    msg_be_l;
   logic [NV-1:0] pend_set_l, pend_clr_l;

   msi_vector_dispatch i_msi_vector_dispatch (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vecs(cfg_log_vecs),
      .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
      .cfg_mask(cfg_mask), .cfg_pending(pend_reg), .cfg_wr(cfg_wr),
      .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready), .req_err(req_err),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
      .msg_be(msg_be), .pend_set(pend_set), .pend_clr(pend_clr));

   msi_vector_dispatch #(.NUM_VEC_MAX(NV), .HAS_ADDR64(1'b0), .HAS_MASK(1'b0)) i_msi_vector_dispatch_lite (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_log_vecs(cfg_log_vecs),
      .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
      .cfg_mask(cfg_mask), .cfg_pending(pend_reg), .cfg_wr(cfg_wr),
      .req_valid(req_valid_l), .req_vec(req_vec), .req_ready(req_ready_l), .req_err(req_err_l),
      .msg_valid(msg_valid_l), .msg_ready(1'b1), .msg_addr(msg_addr_l), .msg_data(msg_data_l),
      .msg_be(msg_be_l), .pend_set(pend_set_l), .pend_clr(pend_clr_l));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model state
   int          m_st, m_idx, m_ret;
   bit          m_sreq;
   logic [63:0] m_addr;
   logic [31:0] m_data;
   int          nx_st, nx_idx, nx_ret;
   bit          nx_sreq;
   logic [63:0] nx_addr;
   logic [31:0] nx_data;
   logic [NV-1:0] nx_pend;

   // observations taken from the design's ports
   logic [15:0]   obs_q[$];
   logic [NV-1:0] obs_set, obs_clr, obs_set_l, obs_clr_l;
   int            err_cnt;

   always @(negedge clk) begin
      if (rst_n) begin
         int n, lgc;
         logic [NV-1:0] rng, e_set, e_clr;
         logic e_ready, e_valid, e_err;
         lgc = (cfg_log_vecs > 3'd5) ? 5 : int'(cfg_log_vecs);
         n = 1 << lgc;
         rng = (n == NV) ? '1 : ((NV'(1) << n) - NV'(1));
         e_ready = (m_st == 0) && !m_sreq;
         e_valid = (m_st == 1);
         e_err = 1'b0; e_set = '0; e_clr = '0;
         nx_st = m_st; nx_idx = m_idx; nx_ret = m_ret; nx_addr = m_addr; nx_data = m_data;
         case (m_st)
            0: begin
               if (m_sreq) begin
                  if (cfg_enable) begin
                     e_clr = pend_reg & ~rng; nx_st = 2; nx_idx = 0;
                  end
               end else if (req_valid && cfg_enable) begin
                  if (int'(req_vec) >= n) e_err = 1'b1;
                  else if (cfg_mask[req_vec]) e_set = NV'(1) << req_vec;
                  else begin
                     nx_addr = {cfg_addr_hi, cfg_addr_lo & 32'hFFFF_FFFC};
                     nx_data = {16'h0, (cfg_data & ~16'(n - 1)) | 16'(req_vec)};
                     nx_st = 1; nx_ret = 0;
                  end
               end
            end
            1: if (msg_ready) nx_st = (m_ret != 0) ? 2 : 0;
            default: begin
               if (!cfg_enable || m_idx >= n) nx_st = 0;
               else if (pend_reg[m_idx] && !cfg_mask[m_idx]) begin
                  e_clr = NV'(1) << m_idx;
                  nx_addr = {cfg_addr_hi, cfg_addr_lo & 32'hFFFF_FFFC};
                  nx_data = {16'h0, (cfg_data & ~16'(n - 1)) | 16'(m_idx)};
                  nx_st = 1; nx_ret = (m_idx != n - 1) ? 1 : 0; nx_idx = m_idx + 1;
               end else if (m_idx == n - 1) nx_st = 0;
               else nx_idx = m_idx + 1;
            end
         endcase
         nx_sreq = (m_sreq && m_st != 0) || (cfg_wr && cfg_enable);
         nx_pend = (pend_reg | e_set) & ~e_clr;

         chk("R8 req_ready", 64'(req_ready), 64'(e_ready));
         chk("R8 msg_valid", 64'(msg_valid), 64'(e_valid));
         chk("R1 req_err", 64'(req_err), 64'(e_err));
         chk("R4 pend_set", 64'(pend_set), 64'(e_set));
         chk("R6 pend_clr", 64'(pend_clr), 64'(e_clr));
         if (e_valid) begin
            chk("R2 msg_addr", msg_addr, m_addr);
            chk("R3 msg_data", 64'(msg_data), 64'(m_data));
            chk("R10 msg_be", 64'(msg_be), 64'hF);
         end

         if (msg_valid && msg_ready) obs_q.push_back(msg_data[15:0]);
         obs_set |= pend_set;
         obs_clr |= pend_clr;
         obs_set_l |= pend_set_l;
         obs_clr_l |= pend_clr_l;
         if (req_err) err_cnt++;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_ret = 0; m_sreq = 1'b0; m_addr = '0; m_data = '0;
         nx_st = 0; nx_idx = 0; nx_ret = 0; nx_sreq = 1'b0; nx_addr = '0; nx_data = '0;
         nx_pend = '0;
         pend_reg <= '0;
      end else begin
         m_st = nx_st; m_idx = nx_idx; m_ret = nx_ret; m_sreq = nx_sreq;
         m_addr = nx_addr; m_data = nx_data;
         pend_reg <= nx_pend;
      end
   end

   always @(posedge clk) begin
      #1;
      case (rdy_mode)
         0: msg_ready = 1'b0;
         1: msg_ready = 1'b1;
         default: msg_ready = 1'($urandom % 2);
      endcase
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog expired actual=%0d expected=<100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic do_req(input int v);
      bit acc;
      req_valid = 1'b1;
      req_vec = VW'(v);
      forever begin
         @(negedge clk);
         acc = req_ready;
         @(posedge clk);
         #1;
         if (acc) break;
      end
      req_valid = 1'b0;
   endtask

   task automatic cfg_write(input logic [NV-1:0] m);
      cfg_mask = m;
      cfg_wr = 1'b1;
      @(posedge clk);
      #1;
      cfg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      while (quiet < 3) begin
         @(negedge clk);
         if (req_ready && !msg_valid) quiet++;
         else quiet = 0;
      end
      @(posedge clk);
      #1;
   endtask

   task automatic clear_obs();
      obs_q.delete();
      obs_set = '0;
      obs_clr = '0;
      err_cnt = 0;
   endtask

   task automatic chk_q(string tag, logic [15:0] exp[$]);
      chk({tag, " count"}, 64'(obs_q.size()), 64'(exp.size()));
      for (int i = 0; i < exp.size() && i < obs_q.size(); i++)
         chk(tag, 64'(obs_q[i]), 64'(exp[i]));
   endtask

   initial begin
      rst_n = 1'b0; rdy_mode = 1; msg_ready = 1'b1;
      cfg_enable = 1'b0; cfg_log_vecs = 3'd0; cfg_addr_lo = '0; cfg_addr_hi = '0;
      cfg_data = '0; cfg_mask = '0; cfg_wr = 1'b0; req_valid = 1'b0; req_valid_l = 1'b0;
      req_vec = '0; obs_set_l = '0; obs_clr_l = '0;
      clear_obs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 reset msg_valid", 64'(msg_valid), 64'h0);
      chk("R12 reset req_ready", 64'(req_ready), 64'h1);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // R2 R3 legal requests with 8 vectors
      cfg_enable = 1'b1; cfg_log_vecs = 3'd3;
      cfg_addr_lo = 32'h1234_5677; cfg_addr_hi = 32'hABCD_0001; cfg_data = 16'h4F3A;
      do_req(0); do_req(5); do_req(7);
      wait_idle();
      chk_q("R3 vector in data", '{16'h4F38, 16'h4F3D, 16'h4F3F});
      clear_obs();

      // R1 illegal vector
      do_req(8);
      wait_idle();
      chk("R1 err count", 64'(err_cnt), 64'd1);
      chk("R1 no message", 64'(obs_q.size()), 64'd0);
      clear_obs();

      // R11 clamp of the count field
      cfg_log_vecs = 3'd7;
      do_req(31);
      wait_idle();
      chk_q("R11 clamp", '{16'h4F3F});
      chk("R11 no error", 64'(err_cnt), 64'd0);
      clear_obs();

      // R3 single vector, R1 vector 1 illegal
      cfg_log_vecs = 3'd0;
      do_req(1); do_req(0);
      wait_idle();
      chk("R1 single vector err", 64'(err_cnt), 64'd1);
      chk_q("R3 single vector data", '{16'h4F3A});
      clear_obs();

      // R9 disabled
      cfg_enable = 1'b0; cfg_log_vecs = 3'd3;
      cfg_mask = 32'h0000_0004;
      do_req(2); do_req(30);
      cfg_write(32'h0);
      wait_idle();
      chk("R9 no pend_set", 64'(obs_set), 64'h0);
      chk("R9 no err", 64'(err_cnt), 64'd0);
      chk("R9 no message", 64'(obs_q.size()), 64'd0);
      chk("R9 no scan clear", 64'(obs_clr), 64'h0);
      clear_obs();

      // R4 masked requests then R6 replay under random sink stalls
      cfg_enable = 1'b1; cfg_log_vecs = 3'd3; rdy_mode = 2;
      cfg_mask = 32'h0000_0054;
      do_req(6); do_req(2); do_req(4);
      wait_idle();
      chk("R4 pending set", 64'(obs_set), 64'h54);
      chk("R4 no message", 64'(obs_q.size()), 64'd0);
      cfg_write(32'h0);
      wait_idle();
      chk_q("R6 ascending replay", '{16'h4F3A, 16'h4F3C, 16'h4F3E});
      chk("R6 cleared", 64'(obs_clr), 64'h54);
      clear_obs();

      // R6 partial unmask
      cfg_mask = 32'h0000_000A;
      do_req(1); do_req(3);
      cfg_write(32'h0000_0002);
      wait_idle();
      chk_q("R6 partial unmask", '{16'h4F3B});
      clear_obs();
      cfg_write(32'h0);
      wait_idle();
      chk_q("R6 second unmask", '{16'h4F39});
      clear_obs();

      // R7 discard of pending beyond a shrunk count
      rdy_mode = 1; cfg_log_vecs = 3'd5; cfg_mask = 32'h0010_0000;
      do_req(20);
      wait_idle();
      chk("R7 pending 20 set", 64'(obs_set), 64'h0010_0000);
      cfg_log_vecs = 3'd3;
      cfg_write(32'h0010_0000);
      wait_idle();
      chk("R7 out of range cleared", 64'(obs_clr), 64'h0010_0000);
      chk("R7 no message", 64'(obs_q.size()), 64'd0);
      clear_obs();

      // R8 back-pressure while a message is held
      cfg_mask = 32'h0; rdy_mode = 0;
      do_req(1);
      req_valid = 1'b1; req_vec = 5'd2;
      repeat (6) begin
         @(negedge clk);
         chk("R8 ready low while held", 64'(req_ready), 64'h0);
         chk("R8 message held", 64'(msg_valid), 64'h1);
      end
      @(posedge clk);
      #1 rdy_mode = 1;
      do_req(2);
      wait_idle();
      chk_q("R8 order after stall", '{16'h4F39, 16'h4F3A});
      clear_obs();

      // R5 R2 variant without masking and with a 32-bit address
      cfg_mask = 32'h0000_0004;
      req_vec = 5'd2; req_valid_l = 1'b1;
      @(posedge clk);
      #1 req_valid_l = 1'b0;
      @(negedge clk);
      chk("R5 masked vector still sent", 64'(msg_valid_l), 64'h1);
      chk("R2 32-bit address", msg_addr_l, 64'h0000_0000_1234_5674);
      chk("R3 lite data", 64'(msg_data_l), 64'h4F3A);
      chk("R10 lite byte enables", 64'(msg_be_l), 64'hF);
      cfg_write(32'h0);
      wait_idle();
      chk("R5 no pending set", 64'(obs_set_l), 64'h0);
      chk("R5 no pending clear", 64'(obs_clr_l), 64'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule